// File: doc/BRIEF.md
# Flash Status Register Protection Controller

This block is the status-and-guard core of a serial NOR flash command engine. The decoder in front of it hands over one-cycle command strobes: latch arm, latch disarm, register write, page program, sector erase and whole-array erase. Each strobe comes with a byte address and the upper six bits of a register write value. The block decides whether each operation may run. It answers with a one-cycle grant or reject pulse, and a granted array or register operation holds the device busy until the external array timer reports completion.

The 8-bit status value is driven continuously, so a status read needs no strobe and always shows the live contents, also while busy. Bit 7 is the register lock flag. Bit 5 is the region side selector. Bits 6 and 4:2 together form a 4-bit protect level, with bit 6 as its most significant bit. Bit 1 is the write-enable latch and bit 0 is write-in-progress. Bits 7:2 are held in flops that reset to a preset value, standing in for nonvolatile cells. Bits 1:0 are volatile and reset to zero.

Command priority when several strobes arrive together: disarm, then arm, then register write, then program or erase, then whole-array erase. The controller is a three-state machine. READY goes to REG_WRITE on a granted register write and to ARRAY_OP on a granted program or erase. Either busy state returns to READY when the array timer reports done.

Top module: `flash_sr_guard`

## Requirements
- R1: After reset, status bits 7:2 equal the preset parameter (default 0), bits 1:0 read 0, busy is 0 and neither grant nor reject is asserted.
- R2: In READY, the arm strobe sets status bit 1 and the disarm strobe clears it.
- R3: A register write, program, erase or whole-array erase issued while bit 1 is 0 gives a reject pulse and is not executed.
- R4: A granted register write loads data bits 7:2 into status bits 7:2 on the grant cycle. Bits 1:0 are not writable. Bit 0 stays 1 until the array timer reports done, and that report clears bits 1 and 0.
- R5: While bit 7 is 1 and the active-low protect pin is low, a register write is rejected and bits 7:2 cannot change. With the pin high, the same write is granted.
- R6: A whole-array erase is granted only when the protect level {bit6,bit4,bit3,bit2} is 0. Otherwise it is rejected.
- R7: A nonzero protect level N covers 2^(N-1) sectors of 2^SECTOR_W bytes each, capped at the whole array. The region sits at the highest addresses when bit 5 is 0 and at the lowest when bit 5 is 1. Program or erase inside the region is rejected, and outside it is granted.
- R8: Any rejected command clears bit 1.
- R9: While bit 0 is 1, all commands including arm and disarm are ignored: no grant, no reject, no status change until done is reported. A done report in READY has no effect.
- R10: Grant and reject are one-cycle pulses in the cycle after the strobe. They are never high together, and a grant coincides with busy rising.
- R11: Simultaneous strobes resolve as disarm over arm, arm over register write, register write over program or erase, and those over whole-array erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_wren | input | 1 | Arm the write-enable latch |
| cmd_wrdi | input | 1 | Disarm the write-enable latch |
| cmd_wrsr | input | 1 | Write status bits 7:2 |
| cmd_prog | input | 1 | Program at cmd_addr |
| cmd_erase | input | 1 | Sector erase at cmd_addr |
| cmd_bulk | input | 1 | Whole-array erase |
| cmd_addr | input | ADDR_W | Byte address for program or erase |
| sr_wdata | input | 6 | New value for status bits 7:2 |
| wp_n | input | 1 | Active-low write-protect pin |
| op_done | input | 1 | Array timer completion pulse |
| status | output | 8 | Live status register value |
| grant | output | 1 | Operation accepted pulse (also starts the timer) |
| reject | output | 1 | Operation refused pulse |
| busy | output | 1 | Operation in progress |

## Verification
A wrong latch value shows up on status bit 1 one cycle after the arm or disarm strobe. It also shows up as an unexpected grant or reject on the next modify command. A protect-range decode fault appears as a grant where a reject was due, on the cycle after the strobe, at the region boundary addresses. A stuck sequencer state shows as bit 0 and busy failing to fall one cycle after done, or as commands being answered while busy.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic [1:0] {
        ST_READY     = 2'd0,
        ST_REG_WRITE = 2'd1,
        ST_ARRAY_OP  = 2'd2
    } seq_state_t;

    typedef enum logic [2:0] {
        ACT_NONE      = 3'd0,
        ACT_SET_WEL   = 3'd1,
        ACT_CLR_WEL   = 3'd2,
        ACT_GRANT_REG = 3'd3,
        ACT_GRANT_ARR = 3'd4,
        ACT_REJECT    = 3'd5
    } action_t;

    localparam int SR_LOCK_BIT = 7;
    localparam int SR_SIDE_BIT = 5;

    function automatic logic [3:0] protect_level(input logic [7:2] nv);
        return {nv[6], nv[4], nv[3], nv[2]};
    endfunction

endpackage

// File: rtl/fsr_region_check.sv
module fsr_region_check #(
    parameter int ADDR_W   = 16,
    parameter int SECTOR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        level,
    input  logic              from_bottom,
    output logic              hit
);
    localparam int SEC_W  = ADDR_W - SECTOR_W;
    localparam int SPAN_W = SEC_W + 1;
    localparam int AW1    = ADDR_W + 1;
    localparam logic [AW1-1:0] ARRAY_BYTES = AW1'(1) << ADDR_W;

    logic [4:0]        level_m1;
    logic [SPAN_W-1:0] span_sec;
    logic [AW1-1:0]    span_bytes;
    logic [AW1-1:0]    addr_x;

    always_comb begin
        level_m1 = {1'b0, level} - 5'd1;
        if (level == 4'd0) begin
            span_sec = '0;
        end else if (int'(level_m1) >= SEC_W) begin
            span_sec = SPAN_W'(1) << SEC_W;
        end else begin
            span_sec = SPAN_W'(1) << level_m1;
        end
        span_bytes = AW1'(span_sec) << SECTOR_W;
        addr_x     = {1'b0, addr};
        if (level == 4'd0) begin
            hit = 1'b0;
        end else if (from_bottom) begin
            hit = addr_x < span_bytes;
        end else begin
            hit = addr_x >= (ARRAY_BYTES - span_bytes);
        end
    end

endmodule

// File: rtl/fsr_cmd_judge.sv
module fsr_cmd_judge
    import fsr_pkg::*;
(
    input  logic    idle,
    input  logic    wel,
    input  logic    locked,
    input  logic    region_hit,
    input  logic    level_zero,
    input  logic    cmd_wren,
    input  logic    cmd_wrdi,
    input  logic    cmd_wrsr,
    input  logic    cmd_prog,
    input  logic    cmd_erase,
    input  logic    cmd_bulk,
    output action_t act
);
    always_comb begin
        act = ACT_NONE;
        if (idle) begin
            if (cmd_wrdi) begin
                act = ACT_CLR_WEL;
            end else if (cmd_wren) begin
                act = ACT_SET_WEL;
            end else if (cmd_wrsr) begin
                if (!wel || locked) act = ACT_REJECT;
                else                act = ACT_GRANT_REG;
            end else if (cmd_prog || cmd_erase) begin
                if (!wel || region_hit) act = ACT_REJECT;
                else                    act = ACT_GRANT_ARR;
            end else if (cmd_bulk) begin
                if (!wel || !level_zero) act = ACT_REJECT;
                else                     act = ACT_GRANT_ARR;
            end
        end
    end

endmodule

// File: rtl/fsr_seq_fsm.sv
module fsr_seq_fsm
    import fsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_reg,
    input  logic go_arr,
    input  logic op_done,
    output logic wip,
    output logic finish
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: begin
                if (go_reg)      state_d = ST_REG_WRITE;
                else if (go_arr) state_d = ST_ARRAY_OP;
            end
            ST_REG_WRITE: if (op_done) state_d = ST_READY;
            ST_ARRAY_OP:  if (op_done) state_d = ST_READY;
            default:      state_d = ST_READY;
        endcase
    end

    always_comb begin
        wip    = 1'b0;
        finish = 1'b0;
        unique case (state_q)
            ST_READY: begin
                wip    = 1'b0;
                finish = 1'b0;
            end
            ST_REG_WRITE, ST_ARRAY_OP: begin
                wip    = 1'b1;
                finish = op_done;
            end
            default: begin
                wip    = 1'b0;
                finish = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/flash_sr_guard.sv
module flash_sr_guard
    import fsr_pkg::*;
#(
    parameter int         ADDR_W    = 16,
    parameter int         SECTOR_W  = 12,
    parameter logic [5:0] NV_PRESET = 6'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_wrsr,
    input  logic              cmd_prog,
    input  logic              cmd_erase,
    input  logic              cmd_bulk,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:2]        sr_wdata,
    input  logic              wp_n,
    input  logic              op_done,
    output logic [7:0]        status,
    output logic              grant,
    output logic              reject,
    output logic              busy
);
    logic [7:2] nv_q;
    logic       wel_q;
    logic       grant_q;
    logic       reject_q;
    logic       wip;
    logic       finish;
    logic       locked;
    logic       region_hit;
    logic [3:0] level;
    action_t    act;

    assign level  = protect_level(nv_q);
    assign locked = nv_q[SR_LOCK_BIT] && !wp_n;

    fsr_region_check #(
        .ADDR_W  (ADDR_W),
        .SECTOR_W(SECTOR_W)
    ) u_region (
        .addr       (cmd_addr),
        .level      (level),
        .from_bottom(nv_q[SR_SIDE_BIT]),
        .hit        (region_hit)
    );

    fsr_cmd_judge u_judge (
        .idle      (!wip),
        .wel       (wel_q),
        .locked    (locked),
        .region_hit(region_hit),
        .level_zero(level == 4'd0),
        .cmd_wren  (cmd_wren),
        .cmd_wrdi  (cmd_wrdi),
        .cmd_wrsr  (cmd_wrsr),
        .cmd_prog  (cmd_prog),
        .cmd_erase (cmd_erase),
        .cmd_bulk  (cmd_bulk),
        .act       (act)
    );

    fsr_seq_fsm u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_reg (act == ACT_GRANT_REG),
        .go_arr (act == ACT_GRANT_ARR),
        .op_done(op_done),
        .wip    (wip),
        .finish (finish)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nv_q     <= NV_PRESET;
            wel_q    <= 1'b0;
            grant_q  <= 1'b0;
            reject_q <= 1'b0;
        end else begin
            grant_q  <= (act == ACT_GRANT_REG) || (act == ACT_GRANT_ARR);
            reject_q <= (act == ACT_REJECT);
            if (finish) begin
                wel_q <= 1'b0;
            end else begin
                case (act)
                    ACT_SET_WEL:            wel_q <= 1'b1;
                    ACT_CLR_WEL, ACT_REJECT: wel_q <= 1'b0;
                    default:                wel_q <= wel_q;
                endcase
            end
            if (act == ACT_GRANT_REG) nv_q <= sr_wdata;
        end
    end

    assign status = {nv_q, wel_q, wip};
    assign grant  = grant_q;
    assign reject = reject_q;
    assign busy   = wip;

endmodule

// File: rtl/fsr_guard_chk.sv
module fsr_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_wrsr,
    input logic       cmd_prog,
    input logic       cmd_erase,
    input logic       cmd_bulk,
    input logic       wp_n,
    input logic       op_done,
    input logic [7:0] status,
    input logic       grant,
    input logic       reject
);
    assert_grant_needs_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> $past(status[1]));

    assert_lock_freezes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7] && !wp_n) |=> $stable(status[7:2]));

    assert_bulk_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_bulk && !cmd_wrsr && !cmd_prog && !cmd_erase &&
         ({status[6], status[4:2]} != 4'd0)) |=> !grant);

    assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] |=> !(grant || reject));

    assert_done_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && op_done) |=> (status[1:0] == 2'b00));

    assert_pulse_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && reject));

    assert_grant_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> status[0]);

endmodule

bind flash_sr_guard fsr_guard_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wrsr (cmd_wrsr),
    .cmd_prog (cmd_prog),
    .cmd_erase(cmd_erase),
    .cmd_bulk (cmd_bulk),
    .wp_n     (wp_n),
    .op_done  (op_done),
    .status   (status),
    .grant    (grant),
    .reject   (reject)
);

// File: tb/test_flash_sr_guard.sv
module test_flash_sr_guard;

    localparam int C_WREN  = 0;
    localparam int C_WRDI  = 1;
    localparam int C_WRSR  = 2;
    localparam int C_PROG  = 3;
    localparam int C_ERASE = 4;
    localparam int C_BULK  = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cmd = '0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        wp_n = 1'b1;
    logic        op_done = 1'b0;
    logic [7:0]  status;
    logic        grant, reject, busy;
    logic        got_g, got_r;
    int          n_run = 0;
    int          n_fail = 0;

    always #2 clk = ~clk;

    flash_sr_guard i_flash_sr_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wren (cmd[C_WREN]),
        .cmd_wrdi (cmd[C_WRDI]),
        .cmd_wrsr (cmd[C_WRSR]),
        .cmd_prog (cmd[C_PROG]),
        .cmd_erase(cmd[C_ERASE]),
        .cmd_bulk (cmd[C_BULK]),
        .cmd_addr (addr),
        .sr_wdata (wdata[7:2]),
        .wp_n     (wp_n),
        .op_done  (op_done),
        .status   (status),
        .grant    (grant),
        .reject   (reject),
        .busy     (busy)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [5:0] c, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cmd = c; addr = a; wdata = d;
        @(negedge clk);
        cmd = '0;
        got_g = grant;
        got_r = reject;
    endtask

    task automatic finish_op();
        @(negedge clk);
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
    endtask

    task automatic set_sr(input logic [7:0] v);
        issue(6'b1 << C_WREN, '0, '0);
        issue(6'b1 << C_WRSR, '0, v);
        finish_op();
    endtask

    task automatic t_reset();
        check("R1 status", status, 8'h00);
        check("R1 busy", {7'd0, busy}, 8'h00);
        check("R1 pulses", {6'd0, grant, reject}, 8'h00);
    endtask

    task automatic t_latch();
        issue(6'b1 << C_WREN, '0, '0);
        check("R2 arm", status, 8'h02);
        issue(6'b1 << C_WRDI, '0, '0);
        check("R2 disarm", status, 8'h00);
    endtask

    task automatic t_no_wel();
        issue(6'b1 << C_PROG, 16'h0000, '0);
        check("R3 prog pulses", {6'd0, got_g, got_r}, 8'h01);
        issue(6'b1 << C_WRSR, '0, 8'hFC);
        check("R3 wrsr pulses", {6'd0, got_g, got_r}, 8'h01);
        check("R3 status kept", status, 8'h00);
    endtask

    task automatic t_sr_write();
        issue(6'b1 << C_WREN, '0, '0);
        issue(6'b1 << C_WRSR, '0, 8'h17);
        check("R4 grant", {6'd0, got_g, got_r}, 8'h02);
        check("R4 busy status", status, 8'h17);
        check("R10 busy pin", {7'd0, busy}, 8'h01);
        finish_op();
        check("R4 after done", status, 8'h14);
        set_sr(8'h00);
        check("R4 restore", status, 8'h00);
    endtask

    task automatic t_protect_top();
        set_sr(8'h04);
        issue(6'b1 << C_WREN, '0, '0);
        issue(6'b1 << C_PROG, 16'hF000, '0);
        check("R7 top inside", {6'd0, got_g, got_r}, 8'h01);
        check("R8 wel cleared", status, 8'h04);
        issue(6'b1 << C_WREN, '0, '0);
        issue(6'b1 << C_PROG, 16'hEFFF, '0);
        check("R7 top outside", {6'd0, got_g, got_r}, 8'h02);
        check("R7 busy status", status, 8'h07);
        finish_op();
        check("R7 after done", status, 8'h04);
    endtask

    task automatic t_protect_bottom();
        set_sr(8'h2C);
        issue(6'b1 << C_WREN, '0, '0);
        issue(6'b1 << C_ERASE, 16'h3FFF, '0);
        check("R7 bottom inside", {6'd0, got_g, got_r}, 8'h01);
        issue(6'b1 << C_WREN, '0, '0);
        issue(6'b1 << C_ERASE, 16'h4000, '0);
        check("R7 bottom outside", {6'd0, got_g, got_r}, 8'h02);
        finish_op();
        check("R7 bottom status", status, 8'h2C);
    endtask

    task automatic t_protect_sat();
        set_sr(8'h40);
        issue(6'b1 << C_WREN, '0, '0);
        issue(6'b1 << C_PROG, 16'h0000, '0);
        check("R7 sat low", {6'd0, got_g, got_r}, 8'h01);
        issue(6'b1 << C_WREN, '0, '0);
        issue(6'b1 << C_PROG, 16'hFFFF, '0);
        check("R7 sat high", {6'd0, got_g, got_r}, 8'h01);
        check("R8 sat status", status, 8'h40);
    endtask

    task automatic t_bulk();
        issue(6'b1 << C_WREN, '0, '0);
        issue(6'b1 << C_BULK, '0, '0);
        check("R6 bulk protected", {6'd0, got_g, got_r}, 8'h01);
        set_sr(8'h00);
        issue(6'b1 << C_WREN, '0, '0);
        issue(6'b1 << C_BULK, '0, '0);
        check("R6 bulk open", {6'd0, got_g, got_r}, 8'h02);
        finish_op();
        check("R6 after done", status, 8'h00);
    endtask

    task automatic t_lock();
        set_sr(8'h80);
        wp_n = 1'b0;
        issue(6'b1 << C_WREN, '0, '0);
        issue(6'b1 << C_WRSR, '0, 8'h00);
        check("R5 locked reject", {6'd0, got_g, got_r}, 8'h01);
        check("R5 locked status", status, 8'h80);
        wp_n = 1'b1;
        issue(6'b1 << C_WREN, '0, '0);
        issue(6'b1 << C_WRSR, '0, 8'h00);
        check("R5 unlocked grant", {6'd0, got_g, got_r}, 8'h02);
        finish_op();
        check("R5 unlocked status", status, 8'h00);
    endtask

    task automatic t_busy();
        issue(6'b1 << C_WREN, '0, '0);
        issue(6'b1 << C_PROG, 16'h1000, '0);
        check("R9 start", status, 8'h03);
        issue(6'b1 << C_WRDI, '0, '0);
        check("R9 disarm ignored", status, 8'h03);
        issue(6'b1 << C_WRSR, '0, 8'hFC);
        check("R9 wrsr no pulse", {6'd0, got_g, got_r}, 8'h00);
        check("R9 wrsr ignored", status, 8'h03);
        finish_op();
        check("R9 done", status, 8'h00);
        finish_op();
        check("R9 idle done ignored", {status[7:1], busy}, 8'h00);
    endtask

    task automatic t_priority();
        issue(6'b1 << C_WREN, '0, '0);
        issue((6'b1 << C_WREN) | (6'b1 << C_WRDI), '0, '0);
        check("R11 disarm wins", status, 8'h00);
        issue(6'b1 << C_WREN, '0, '0);
        issue((6'b1 << C_WRSR) | (6'b1 << C_PROG), 16'h0000, 8'h20);
        check("R11 wrsr wins", status, 8'h23);
        finish_op();
        check("R11 after done", status, 8'h20);
        set_sr(8'h00);
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch();
        t_no_wel();
        t_sr_write();
        t_protect_top();
        t_protect_bottom();
        t_protect_sat();
        t_bulk();
        t_lock();
        t_busy();
        t_priority();
    endtask

    initial begin
        fork
            run_all();
            begin
                #800000;
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule